// File: doc/BRIEF.md
# Character Display Controller

This block models the command side of a parallel character display controller. A host drives three control lines: register select, read/write and enable, packed into one 3-bit control input, together with an 8-bit byte. The block synchronises enable into its own clock domain and acts on the falling edge of enable. It holds 128 bytes of character memory, a 7-bit cursor address, an entry direction, display control bits, a line-count flag, and a busy hold-off timer.

Instruction writes (register select low) clear the screen, set the cursor, choose the entry direction, or set display and function options. Data writes (register select high) store a character at the cursor and then step the cursor. The cursor skips the gap between the two 40-cell lines. Reads return either the busy flag and the cursor address, or the character under the cursor. The output byte is enabled only while enable is high and read is selected. After every accepted write the block stays busy for a fixed number of clock cycles. Writes that arrive during that window are dropped.

Top module: `chr_lcd_ctrl`

## Requirements
- R1: Control input bit 2 is register select (1 = data), bit 1 is read/write (1 = read) and bit 0 is enable; a write changes state only after enable falls, three clock edges after the fall reaches the input.
- R2: The output enable is high, and data_o is non-zero only, while the synchronised enable is high and read is selected; otherwise data_o is 0x00.
- R3: A status read (select 0, read 1) returns the busy flag in bit 7 and the cursor address in bits 6:0.
- R4: A data write (select 1, write) stores the byte at the cursor and then steps the cursor in the entry direction.
- R5: Incrementing steps the cursor from 0x27 to 0x40 and from 0x67 to 0x00; other addresses step by +1.
- R6: Entry instruction 0x04..0x07 sets the direction from bit 1 (1 = increment, 0 = decrement); decrementing steps 0x00 to 0x67 and 0x40 to 0x27.
- R7: Instruction 0x01 writes 0x20 into all 128 character cells and sets the cursor to 0x00.
- R8: An instruction with bit 7 set loads bits 6:0 into the cursor (0xC0 gives 0x40).
- R9: Every accepted write sets busy for BUSY_CYCLES clock cycles; writes whose enable falls while busy is set have no effect.
- R10: Instruction 0x08..0x0F copies bits 2:0 to disp_ctl_o; instruction 0x20..0x3F copies bit 3 to lines2_o.
- R11: Instructions are decoded by their highest set bit; those whose highest set bit is 6, 4 or 1 change neither cursor nor memory, but still set busy.
- R12: After reset the cursor is 0x00, the direction is increment, every cell holds 0x20, busy is clear, and disp_ctl_o and lines2_o are 0.
- R13: A data read (select 1, read) returns the cell under the cursor and leaves the cursor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 3 | {register select, read/write, enable} |
| data_i | input | 8 | Byte written by the host |
| data_o | output | 8 | Byte returned on reads, 0 when not driven |
| data_oe_o | output | 1 | High while the block drives the byte lanes |
| disp_ctl_o | output | 3 | Display, cursor and blink bits from the last display instruction |
| lines2_o | output | 1 | Two-line flag from the last function-set instruction |

## Verification
The bench builds the block with BUSY_CYCLES set to 20 and the default two synchroniser stages. This keeps each hold-off short enough to step through many instructions. It also lets one write land inside the busy window of the previous one, and lets a status read catch busy while it is still set. With these values both cursor wrap pairs, both entry directions and the clear can all be reached in a few thousand cycles.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
    localparam int ADDR_W    = 7;
    localparam int DATA_W    = 8;
    localparam int RAM_DEPTH = 2 ** ADDR_W;

    localparam logic [ADDR_W-1:0] ROW0_LAST  = 7'h27;
    localparam logic [ADDR_W-1:0] ROW1_FIRST = 7'h40;
    localparam logic [ADDR_W-1:0] ROW1_LAST  = 7'h67;
    localparam logic [DATA_W-1:0] BLANK_CHAR = 8'h20;

    typedef struct packed {
        logic [RAM_DEPTH-1:0][DATA_W-1:0] ram;
        logic [ADDR_W-1:0]                addr;
        logic                             inc;
        logic [2:0]                       disp;
        logic                             lines2;
    } lcd_state_t;
endpackage

// File: rtl/lcd_en_sync.sv
module lcd_en_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_raw_i,
    output logic en_sync_o,
    output logic en_fall_o
);
    localparam int ST = (STAGES < 2) ? 2 : STAGES;

    logic [ST-1:0] sync_d, sync_q;
    logic          prev_d, prev_q;

    always_comb begin
        sync_d = {sync_q[ST-2:0], en_raw_i};
        prev_d = sync_q[ST-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign en_sync_o = sync_q[ST-1];
    assign en_fall_o = prev_q & ~sync_q[ST-1];
endmodule

// File: rtl/lcd_busy_timer.sv
module lcd_busy_timer #(
    parameter int BUSY_CYCLES = 6250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i)
            cnt_d = CNT_W'(BUSY_CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/lcd_addr_step.sv
module lcd_addr_step
    import lcd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);
    always_comb begin
        if (inc_i) begin
            if (addr_i == ROW0_LAST)      addr_o = ROW1_FIRST;
            else if (addr_i == ROW1_LAST) addr_o = '0;
            else                          addr_o = addr_i + 1'b1;
        end else begin
            if (addr_i == '0)              addr_o = ROW1_LAST;
            else if (addr_i == ROW1_FIRST) addr_o = ROW0_LAST;
            else                           addr_o = addr_i - 1'b1;
        end
    end
endmodule

// File: rtl/chr_lcd_ctrl.sv
module chr_lcd_ctrl
    import lcd_pkg::*;
#(
    parameter int BUSY_CYCLES = 6250,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        ctrl_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic [2:0]        disp_ctl_o,
    output logic              lines2_o
);
    logic              sel_data, rd_sel;
    logic              en_sync, en_fall, busy, start;
    logic [ADDR_W-1:0] step_addr, addr_q;
    logic              inc_q;
    lcd_state_t        st_d, st_q;

    assign sel_data = ctrl_i[2];
    assign rd_sel   = ctrl_i[1];

    lcd_en_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .en_raw_i(ctrl_i[0]),
        .en_sync_o(en_sync), .en_fall_o(en_fall)
    );

    lcd_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy)
    );

    lcd_addr_step u_step (
        .addr_i(st_q.addr), .inc_i(st_q.inc), .addr_o(step_addr)
    );

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (en_fall && !rd_sel && !busy) begin
            start = 1'b1;
            if (sel_data) begin
                st_d.ram[st_q.addr] = data_i;
                st_d.addr           = step_addr;
            end else if (data_i[7]) begin
                st_d.addr = data_i[6:0];
            end else if (data_i[6]) begin
                st_d = st_q;
            end else if (data_i[5]) begin
                st_d.lines2 = data_i[3];
            end else if (data_i[4]) begin
                st_d = st_q;
            end else if (data_i[3]) begin
                st_d.disp = data_i[2:0];
            end else if (data_i[2]) begin
                st_d.inc = data_i[1];
            end else if (data_i[1]) begin
                st_d = st_q;
            end else if (data_i[0]) begin
                st_d.ram  = {RAM_DEPTH{BLANK_CHAR}};
                st_d.addr = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ram    <= {RAM_DEPTH{BLANK_CHAR}};
            st_q.addr   <= '0;
            st_q.inc    <= 1'b1;
            st_q.disp   <= '0;
            st_q.lines2 <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        data_oe_o = en_sync & rd_sel;
        data_o    = '0;
        if (data_oe_o)
            data_o = sel_data ? st_q.ram[st_q.addr] : {busy, st_q.addr};
    end

    assign disp_ctl_o = st_q.disp;
    assign lines2_o   = st_q.lines2;
    assign addr_q     = st_q.addr;
    assign inc_q      = st_q.inc;
endmodule

// File: rtl/chr_lcd_ctrl_chk.sv
module chr_lcd_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] ctrl_i,
    input logic [7:0] data_i,
    input logic       data_oe_o,
    input logic       en_fall,
    input logic       busy,
    input logic [6:0] addr_q,
    input logic       inc_q
);
    // R2
    oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> ctrl_i[1]);

    // R9
    busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && !ctrl_i[1] && !busy) |=> busy);

    // R9
    drop_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && !ctrl_i[1] && busy) |=> $stable(addr_q));

    // R8
    set_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && !ctrl_i[1] && !ctrl_i[2] && !busy && data_i[7])
        |=> (addr_q == $past(data_i[6:0])));

    // R7
    clear_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && !ctrl_i[1] && !ctrl_i[2] && !busy && data_i == 8'h01)
        |=> (addr_q == 7'h00));

    // R5
    row_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_fall && !ctrl_i[1] && ctrl_i[2] && !busy && inc_q && addr_q == 7'h27)
        |=> (addr_q == 7'h40));
endmodule

bind chr_lcd_ctrl chr_lcd_ctrl_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl_i), .data_i(data_i),
    .data_oe_o(data_oe_o), .en_fall(en_fall), .busy(busy),
    .addr_q(addr_q), .inc_q(inc_q)
);

// File: tb/chr_lcd_ctrl_tb_top.sv
module chr_lcd_ctrl_tb_top;
    localparam int BUSY = 20;
    localparam int NV   = 11;
    // {select, byte, expected cursor after the write}
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 8'h38, 7'h00}, {1'b0, 8'h0E, 7'h00}, {1'b0, 8'h06, 7'h00},
        {1'b1, 8'h48, 7'h01}, {1'b1, 8'h49, 7'h02}, {1'b0, 8'hC0, 7'h40},
        {1'b1, 8'h58, 7'h41}, {1'b0, 8'h95, 7'h15}, {1'b0, 8'h40, 7'h15},
        {1'b0, 8'h10, 7'h15}, {1'b0, 8'h02, 7'h15}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] ctrl = 3'b000;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       oe;
    logic [2:0] disp;
    logic       lines2;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    chr_lcd_ctrl #(.BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .data_i(din),
        .data_o(dout), .data_oe_o(oe), .disp_ctl_o(disp), .lines2_o(lines2)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [7:0] d, input int settle);
        @(negedge clk);
        ctrl = {sel, 1'b0, 1'b1};
        din  = d;
        repeat (3) @(negedge clk);
        ctrl[0] = 1'b0;
        repeat (settle) @(negedge clk);
    endtask

    task automatic bus_read(input logic sel, output logic [7:0] d, output logic drv);
        @(negedge clk);
        ctrl = {sel, 1'b1, 1'b1};
        repeat (3) @(negedge clk);
        d   = dout;
        drv = oe;
        ctrl[0] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 0x%02h expected 0x%02h", 8'h01, 8'h00);
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic       d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12 reset state
        bus_read(1'b0, r, d);
        check("R12 status", r, 8'h00);
        check("R3 oe on status read", {7'd0, d}, 8'h01);
        bus_read(1'b1, r, d);
        check("R12 blank cell", r, 8'h20);
        check("R12 disp", {5'd0, disp}, 8'h00);
        check("R2 idle bus", dout, 8'h00);

        // R4 R8 R11 vector table
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][15], VEC[i][14:7], BUSY + 6);
            bus_read(1'b0, r, d);
            check("R4 R8 R11 vector cursor", r, {1'b0, VEC[i][6:0]});
        end

        // R10 option registers
        check("R10 disp_ctl", {5'd0, disp}, 8'h06);
        check("R10 lines2", {7'd0, lines2}, 8'h01);

        // R13 data read, no cursor move
        bus_write(1'b0, 8'h80, BUSY + 6);
        bus_read(1'b1, r, d);
        check("R13 cell 0", r, 8'h48);
        bus_read(1'b0, r, d);
        check("R13 cursor kept", r, 8'h00);
        bus_write(1'b0, 8'hC0, BUSY + 6);
        bus_read(1'b1, r, d);
        check("R4 cell 0x40", r, 8'h58);

        // R2 write with enable high: bus not driven
        @(negedge clk);
        ctrl = 3'b001;
        repeat (3) @(negedge clk);
        check("R2 oe on write", {7'd0, oe}, 8'h00);
        check("R2 data on write", dout, 8'h00);
        ctrl = 3'b000;
        repeat (BUSY + 6) @(negedge clk);

        // R1 R9 busy window and dropped write
        bus_write(1'b0, 8'h80, 4);
        bus_read(1'b0, r, d);
        check("R9 R3 busy seen", r, 8'h80);
        bus_write(1'b0, 8'h90, 4);
        repeat (BUSY + 10) @(negedge clk);
        bus_read(1'b0, r, d);
        check("R9 dropped write", r, 8'h00);

        // R1 no change before enable falls
        @(negedge clk);
        ctrl = 3'b001;
        din  = 8'h85;
        repeat (BUSY) @(negedge clk);
        ctrl = 3'b011;
        repeat (3) @(negedge clk);
        check("R1 held enable", dout, 8'h00);
        ctrl = 3'b000;
        repeat (BUSY + 6) @(negedge clk);

        // R5 increment wraps
        bus_write(1'b0, 8'hA7, BUSY + 6);
        bus_write(1'b1, 8'h41, BUSY + 6);
        bus_read(1'b0, r, d);
        check("R5 wrap 0x27", r, 8'h40);
        bus_write(1'b0, 8'hE7, BUSY + 6);
        bus_write(1'b1, 8'h42, BUSY + 6);
        bus_read(1'b0, r, d);
        check("R5 wrap 0x67", r, 8'h00);

        // R6 decrement wraps
        bus_write(1'b0, 8'h04, BUSY + 6);
        bus_write(1'b0, 8'hC0, BUSY + 6);
        bus_write(1'b1, 8'h43, BUSY + 6);
        bus_read(1'b0, r, d);
        check("R6 wrap 0x40", r, 8'h27);
        bus_write(1'b0, 8'h80, BUSY + 6);
        bus_write(1'b1, 8'h44, BUSY + 6);
        bus_read(1'b0, r, d);
        check("R6 wrap 0x00", r, 8'h67);
        bus_write(1'b0, 8'h06, BUSY + 6);

        // R7 clear
        bus_write(1'b0, 8'hC0, BUSY + 6);
        bus_write(1'b0, 8'h01, BUSY + 6);
        bus_read(1'b0, r, d);
        check("R7 cursor home", r, 8'h00);
        bus_read(1'b1, r, d);
        check("R7 cell 0 blank", r, 8'h20);
        bus_write(1'b0, 8'hC0, BUSY + 6);
        bus_read(1'b1, r, d);
        check("R7 cell 0x40 blank", r, 8'h20);

        finish_run();
    end
endmodule